// File: doc/BRIEF.md
# Two-Operand Integer ALU with Condition Flags

This block is the integer execution stage of a small two-operand processor. Each operation combines a destination operand `Ra` with a second operand. The second operand is always the sum of a sign-extended immediate and a source register value. The block returns a result meant for `Ra`, a write-back strobe, a flag-update strobe and four condition flags. The operations are add, subtract, AND, OR, XOR, three shifts, bit reversal, a low-half merge, move, compare and test.

One operation is accepted per cycle when `in_valid` is high. The result and strobes are registered, so they appear one cycle later together with a single-cycle `out_valid` pulse. Compare and test only change the flags. Move, bit reverse and low-half merge only write the register. The sequencer uses the two strobes to commit the result to the register file and to the condition register.

Top module: `alu2op`

## Requirements
- R1: The second operand B is `imm + rb`, truncated to 32 bits. Opcode 2 (ADD) writes `ra + B` and opcode 0 (SUB) writes `ra - B`. Both assert write-back and flag update.
- R2: Opcode 1 (AND), 3 (OR) and 4 (XOR) write the bitwise result of `ra` and B. Opcode 10 (MOV) writes B.
- R3: Flags are packed as `flags[0]`=zero, `[1]`=carry, `[2]`=negative, `[3]`=overflow. Zero means the 32-bit result is all zeros, and negative is result bit 31. AND, OR, XOR, TEST and all shifts clear overflow. AND, OR, XOR and TEST also clear carry.
- R4: ADD sets carry to the unsigned carry out. SUB and CMP set carry when `ra < B` as unsigned numbers. ADD, SUB and CMP set overflow when the true signed result does not fit in 32 bits.
- R5: Opcode 5 (logical right) and opcode 6 (left) take the full 32-bit B as the shift count, with no clamping. A count of 33 or more gives zero, and 32 gives zero. Carry is the last bit shifted out of `ra`, and 0 when the count is 0 or above 32.
- R6: Opcode 7 (arithmetic right) fills vacated bits with `ra[31]`. For a count of 32 or more, every result bit and the carry equal `ra[31]`. Otherwise carry is the last bit shifted out, and 0 when the count is 0.
- R7: Opcode 8 (BREV) writes B with its bits reversed, so B bit i lands in result bit 31-i.
- R8: Opcode 9 (LDLO) writes `{ra[31:16], B[15:0]}`.
- R9: Opcode 11 (CMP) sets the flags as SUB does, and opcode 12 (TEST) sets them as AND does. Neither asserts write-back.
- R10: MOV, BREV and LDLO never assert flag update, and the `flags` output keeps its previous value after them.
- R11: Opcodes 13 to 31 assert neither write-back nor flag update, and leave `flags` unchanged.
- R12: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. In idle cycles both strobes are low and `result` and `flags` hold. After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 5 | Operation code |
| ra | input | 32 | Destination operand value |
| rb | input | 32 | Source register value |
| imm | input | 32 | Sign-extended immediate |
| out_valid | output | 1 | Registered result present |
| result | output | 32 | Value for Ra |
| wb_en | output | 1 | Commit result to Ra |
| flags_we | output | 1 | Commit flags to the condition register |
| flags | output | 4 | {overflow, negative, carry, zero} |

## Verification
Each shift opcode is driven with single-bit, alternating and sign-heavy patterns over every count from 0 to 40, plus 2^31 and all-ones. This separates an off-by-one in the carry position from a wrong count clamp, and a wrong sign fill from a logical fill. Add and subtract are driven at the signed and unsigned boundaries, which tells a carry fault from an overflow fault. The immediate and register are split so that a missing `imm` addend shows up. A pseudo-random sweep covers all 32 opcodes. The bench tracks the last committed flags, so any stray flag or write strobe on MOV, BREV, LDLO or an unassigned code is caught, as is a write strobe on compare or test.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [4:0] {
        OP_SUB  = 5'd0,
        OP_AND  = 5'd1,
        OP_ADD  = 5'd2,
        OP_OR   = 5'd3,
        OP_XOR  = 5'd4,
        OP_LSR  = 5'd5,
        OP_LSL  = 5'd6,
        OP_ASR  = 5'd7,
        OP_BREV = 5'd8,
        OP_LDLO = 5'd9,
        OP_MOV  = 5'd10,
        OP_CMP  = 5'd11,
        OP_TST  = 5'd12
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_RIGHT = 2'd0,
        SH_LEFT  = 2'd1,
        SH_ARITH = 2'd2
    } shift_kind_e;

    typedef struct packed {
        logic v;
        logic n;
        logic c;
        logic z;
    } alu_flags_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         carry,
    output logic         ovf
);
    localparam int MSB = W - 1;

    logic [W:0] wide;

    always_comb begin
        if (sub) begin
            wide = {1'b0, a} - {1'b0, b};
        end else begin
            wide = {1'b0, a} + {1'b0, b};
        end
        res   = wide[W-1:0];
        carry = wide[W];
        if (sub) begin
            ovf = (a[MSB] != b[MSB]) && (res[MSB] != a[MSB]);
        end else begin
            ovf = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
        end
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] amt,
    input  shift_kind_e  kind,
    output logic [W-1:0] res,
    output logic         carry
);
    logic        [W:0] right_ext;
    logic        [W:0] left_ext;
    logic signed [W:0] arith_ext;

    always_comb begin
        right_ext = {a, 1'b0} >> amt;
        left_ext  = {1'b0, a} << amt;
        arith_ext = $signed({a, 1'b0}) >>> amt;
        unique case (kind)
            SH_LEFT: begin
                res   = left_ext[W-1:0];
                carry = left_ext[W];
            end
            SH_ARITH: begin
                res   = arith_ext[W:1];
                carry = arith_ext[0];
            end
            default: begin
                res   = right_ext[W:1];
                carry = right_ext[0];
            end
        endcase
    end
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] res
);
    localparam int HALF = W / 2;

    logic [W-1:0] b_rev;

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign b_rev[i] = b[W-1-i];
    end

    always_comb begin
        unique case (op)
            OP_AND, OP_TST: res = a & b;
            OP_OR:          res = a | b;
            OP_XOR:         res = a ^ b;
            OP_BREV:        res = b_rev;
            OP_LDLO:        res = {a[W-1:HALF], b[HALF-1:0]};
            default:        res = b;
        endcase
    end
endmodule

// File: rtl/alu2op.sv
module alu2op
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [4:0]   op,
    input  logic [W-1:0] ra,
    input  logic [W-1:0] rb,
    input  logic [W-1:0] imm,
    output logic         out_valid,
    output logic [W-1:0] result,
    output logic         wb_en,
    output logic         flags_we,
    output logic [3:0]   flags
);
    localparam int MSB  = W - 1;
    localparam int HALF = W / 2;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] res;
        logic         wb;
        logic         fwe;
        alu_flags_t   flg;
    } alu_state_t;

    alu_state_t state_d, state_q;

    alu_op_e      op_e;
    logic [W-1:0] opb;
    logic [W-1:0] as_res, sh_res, bit_res;
    logic         as_c, as_v, sh_c;
    logic         is_sub;
    shift_kind_e  sh_kind;

    assign op_e   = alu_op_e'(op);
    assign opb    = imm + rb;
    assign is_sub = (op_e == OP_SUB) || (op_e == OP_CMP);

    always_comb begin
        unique case (op_e)
            OP_LSL:  sh_kind = SH_LEFT;
            OP_ASR:  sh_kind = SH_ARITH;
            default: sh_kind = SH_RIGHT;
        endcase
    end

    alu_addsub #(.W(W)) u_addsub (
        .a(ra), .b(opb), .sub(is_sub),
        .res(as_res), .carry(as_c), .ovf(as_v)
    );

    alu_shift #(.W(W)) u_shift (
        .a(ra), .amt(opb), .kind(sh_kind),
        .res(sh_res), .carry(sh_c)
    );

    alu_bitops #(.W(W)) u_bitops (
        .a(ra), .b(opb), .op(op_e), .res(bit_res)
    );

    always_comb begin
        logic [W-1:0] r;
        logic         c, v, wb, fwe;
        r   = bit_res;
        c   = 1'b0;
        v   = 1'b0;
        wb  = 1'b0;
        fwe = 1'b0;
        unique case (op_e)
            OP_ADD, OP_SUB: begin
                r = as_res; c = as_c; v = as_v; wb = 1'b1; fwe = 1'b1;
            end
            OP_CMP: begin
                r = as_res; c = as_c; v = as_v; fwe = 1'b1;
            end
            OP_LSR, OP_LSL, OP_ASR: begin
                r = sh_res; c = sh_c; wb = 1'b1; fwe = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR: begin
                wb = 1'b1; fwe = 1'b1;
            end
            OP_TST:                   fwe = 1'b1;
            OP_MOV, OP_BREV, OP_LDLO: wb  = 1'b1;
            default: ;
        endcase

        state_d     = state_q;
        state_d.vld = in_valid;
        state_d.wb  = 1'b0;
        state_d.fwe = 1'b0;
        if (in_valid) begin
            state_d.res = r;
            state_d.wb  = wb;
            state_d.fwe = fwe;
            if (fwe) begin
                state_d.flg.z = (r == '0);
                state_d.flg.n = r[MSB];
                state_d.flg.c = c;
                state_d.flg.v = v;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign result    = state_q.res;
    assign wb_en     = state_q.wb;
    assign flags_we  = state_q.fwe;
    assign flags     = state_q.flg;

    assert_valid_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wb_en && !flags_we && $stable(result) && $stable(flags)));
    assert_cmp_no_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == 5'd11 || op == 5'd12)) |=> (!wb_en && flags_we));
    assert_keep_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == 5'd8 || op == 5'd9 || op == 5'd10)) |=> (!flags_we && wb_en && $stable(flags)));
    assert_unused_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op > 5'd12) |=> (!flags_we && !wb_en));
    assert_zero_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && wb_en && flags_we) |-> (flags[0] == (result == '0) && flags[2] == result[MSB]));
    assert_ldlo_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 5'd9) |=> (result[W-1:HALF] == $past(ra[W-1:HALF])));
    assert_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !in_valid) |=> !out_valid);
endmodule

// File: tb/alu2op_bench.sv
module alu2op_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [4:0]  op;
    logic [31:0] ra, rb, imm;
    logic        out_valid, wb_en, flags_we;
    logic [31:0] result;
    logic [3:0]  flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [3:0]  last_flags;
    logic [31:0] last_result;

    always #5 clk = ~clk;

    alu2op u_alu2op (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .ra(ra), .rb(rb), .imm(imm), .out_valid(out_valid),
        .result(result), .wb_en(wb_en), .flags_we(flags_we), .flags(flags)
    );

    function automatic string req_of(input logic [4:0] o);
        case (o)
            5'd0, 5'd2:       return "R1/R4";
            5'd1, 5'd3, 5'd4: return "R2/R3";
            5'd5, 5'd6:       return "R5";
            5'd7:             return "R6";
            5'd8:             return "R7/R10";
            5'd9:             return "R8/R10";
            5'd10:            return "R2/R10";
            5'd11, 5'd12:     return "R9";
            default:          return "R11";
        endcase
    endfunction

    // Reference model: returns {wb, fwe, flags[3:0], result[31:0]}
    function automatic logic [37:0] model(input logic [4:0] o, input logic [31:0] a,
                                          input logic [31:0] rr, input logic [31:0] im);
        logic [31:0] b, r;
        logic        c, v, wb, fwe;
        longint      sres;
        longint unsigned ures;
        int          n;
        b = im + rr;
        r = 32'h0; c = 1'b0; v = 1'b0; wb = 1'b0; fwe = 1'b0;
        n = (b > 32'd40) ? 40 : int'(b);
        case (o)
            5'd2: begin
                ures = longint'(a) + longint'(b);
                r = ures[31:0]; c = ures[32];
                sres = longint'($signed(a)) + longint'($signed(b));
                v = (sres > 64'sd2147483647) || (sres < -64'sd2147483648);
                wb = 1; fwe = 1;
            end
            5'd0, 5'd11: begin
                r = a - b; c = (a < b);
                sres = longint'($signed(a)) - longint'($signed(b));
                v = (sres > 64'sd2147483647) || (sres < -64'sd2147483648);
                wb = (o == 5'd0); fwe = 1;
            end
            5'd1, 5'd12: begin r = a & b; wb = (o == 5'd1); fwe = 1; end
            5'd3: begin r = a | b; wb = 1; fwe = 1; end
            5'd4: begin r = a ^ b; wb = 1; fwe = 1; end
            5'd5: begin
                r = a;
                for (int i = 0; i < n; i++) begin c = r[0]; r = r >> 1; end
                wb = 1; fwe = 1;
            end
            5'd6: begin
                r = a;
                for (int i = 0; i < n; i++) begin c = r[31]; r = r << 1; end
                wb = 1; fwe = 1;
            end
            5'd7: begin
                r = a;
                for (int i = 0; i < n; i++) begin c = r[0]; r = {r[31], r[31:1]}; end
                wb = 1; fwe = 1;
            end
            5'd8: begin
                for (int i = 0; i < 32; i++) r[31-i] = b[i];
                wb = 1;
            end
            5'd9:  begin r = {a[31:16], b[15:0]}; wb = 1; end
            5'd10: begin r = b; wb = 1; end
            default: ;
        endcase
        return {wb, fwe, v, r[31], c, (r == 32'h0), r};
    endfunction

    task automatic apply(input logic [4:0] o, input logic [31:0] a,
                         input logic [31:0] rr, input logic [31:0] im);
        logic [37:0] e;
        logic [3:0]  ef;
        e = model(o, a, rr, im);
        @(negedge clk);
        in_valid = 1'b1; op = o; ra = a; rb = rr; imm = im;
        @(negedge clk);
        in_valid = 1'b0;
        ef = e[36] ? e[35:32] : last_flags;
        checks++;
        if (out_valid !== 1'b1 || wb_en !== e[37] || flags_we !== e[36] ||
            flags !== ef || (e[37] && result !== e[31:0])) begin
            fails++;
            $display("FAIL %s op=%0d ra=%h b=%h: got vld=%b wb=%b fwe=%b flg=%h res=%h, exp vld=1 wb=%b fwe=%b flg=%h res=%h",
                     req_of(o), o, a, rr + im, out_valid, wb_en, flags_we, flags, result,
                     e[37], e[36], ef, e[31:0]);
        end
        last_flags  = flags;
        last_result = result;
    endtask

    task automatic idle_check();
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || wb_en !== 1'b0 || flags_we !== 1'b0 ||
            result !== last_result || flags !== last_flags) begin
            fails++;
            $display("FAIL R12 idle: got vld=%b wb=%b fwe=%b res=%h flg=%h, exp 0 0 0 res=%h flg=%h",
                     out_valid, wb_en, flags_we, result, flags, last_result, last_flags);
        end
    endtask

    initial begin
        logic [31:0] pats [8];
        logic [31:0] lfsr;
        pats[0] = 32'h0000_0001; pats[1] = 32'h8000_0000; pats[2] = 32'hAAAA_5555;
        pats[3] = 32'hFFFF_FFFF; pats[4] = 32'h1234_5678; pats[5] = 32'h8000_0001;
        pats[6] = 32'h7FFF_FFFE; pats[7] = 32'h0000_0000;
        rst_n = 1'b0; in_valid = 1'b0; op = '0; ra = '0; rb = '0; imm = '0;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 0 || wb_en !== 0 || flags_we !== 0 || flags !== 0 || result !== 0) begin
            fails++;
            $display("FAIL R12 reset: got vld=%b wb=%b fwe=%b flg=%h res=%h, exp all zero",
                     out_valid, wb_en, flags_we, flags, result);
        end
        rst_n = 1'b1;
        last_flags = 4'h0; last_result = 32'h0;

        // R5/R6 shift sweeps, count split across imm and rb
        for (int k = 5; k <= 7; k++)
            for (int p = 0; p < 8; p++) begin
                for (int s = 0; s <= 40; s++)
                    apply(5'(k), pats[p], 32'(s / 2), 32'(s - s / 2));
                apply(5'(k), pats[p], 32'h8000_0000, 32'h0);
                apply(5'(k), pats[p], 32'hFFFF_FFF0, 32'h0000_000F);
            end

        // R1/R4 boundaries for add, sub and compare
        for (int k = 0; k <= 11; k += 11)
            for (int p = 0; p < 8; p++)
                for (int q = 0; q < 8; q++)
                    apply(5'(k), pats[p], pats[q] - 32'd3, 32'd3);
        for (int p = 0; p < 8; p++)
            for (int q = 0; q < 8; q++)
                apply(5'd2, pats[p], pats[q], 32'h0);

        // R12 idle behaviour after a flag-writing op
        apply(5'd0, 32'd5, 32'd5, 32'd0);
        idle_check();
        idle_check();

        // R10/R11 flags must survive non-flag ops
        apply(5'd11, 32'h0, 32'h1, 32'h0);
        apply(5'd10, 32'h0, 32'h0, 32'h0);
        apply(5'd8,  32'h0, 32'h1, 32'h0);
        apply(5'd9,  32'hDEAD_BEEF, 32'h0, 32'h0);
        apply(5'd20, 32'h0, 32'h0, 32'h0);
        apply(5'd31, 32'hFFFF_FFFF, 32'h0, 32'h1);

        // Pseudo-random sweep over all 32 codes
        lfsr = 32'hACE1_2345;
        for (int k = 0; k < 32; k++)
            for (int j = 0; j < 40; j++) begin
                logic [31:0] x, y, z;
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; x = lfsr;
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; y = lfsr;
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; z = lfsr;
                if (k >= 5 && k <= 7) z = {26'h0, z[5:0]} - y;
                apply(5'(k), x, y, z);
            end
        idle_check();

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule